// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised storage register, eight bits wide by default. On each rising clock edge it shifts toward the high end, shifts toward the low end, loads in parallel or holds, as a two-bit select input chooses. An active-low reset clears it at once, without waiting for a clock edge. Parallel data comes in and goes out on one shared bus. For synthesis that bus is split into three signals: an input vector, an output vector and a drive-enable bit. The pad logic around the block combines these three into a tri-state pin set.

The register value always appears on the bus output vector. The drive enable goes low when either of two active-low enables is high. It also goes low whenever load mode is selected, which frees the bus for an external source. The lowest and highest bits also leave the block on two dedicated serial outputs. These outputs are never gated, so several copies can be chained into a longer register. The select, serial and enable pins are plain control signals with no handshake: the block acts on every clock edge.

Top module: `usr_shift_reg`

## Requirements
- R1: With `sel` = 2'b11 (load), a rising edge copies `bus_in` into the register.
- R2: With `sel` = 2'b01 (shift up), a rising edge moves bit n to bit n+1 and puts `ser_in_up` into bit 0.
- R3: With `sel` = 2'b10 (shift down), a rising edge moves bit n to bit n-1 and puts `ser_in_dn` into bit WIDTH-1.
- R4: With `sel` = 2'b00 (hold), a rising edge leaves the register unchanged.
- R5: While `rst_n` is low, the register reads all zeros. This takes effect as soon as `rst_n` falls, without a clock edge, and it overrides the clock and `sel`.
- R6: `bus_drive_en` is 0 whenever `oe_a_n` or `oe_b_n` is 1.
- R7: `bus_drive_en` is 0 whenever `sel` = 2'b11, whatever the enables. When both enables are 0 and `sel` is not 2'b11, it is 1.
- R8: Shifting, loading, holding and reset behave the same while `bus_drive_en` is 0.
- R9: `ser_out_lo` always equals bit 0 and `ser_out_hi` always equals bit WIDTH-1, whatever the enables.
- R10: `bus_out` always equals the register value. `bus_in` has no effect unless `sel` = 2'b11.
- R11: Two copies can be chained into one register of twice the width. The lower copy's `ser_out_hi` feeds the upper copy's `ser_in_up`, and the upper copy's `ser_out_lo` feeds the lower copy's `ser_in_dn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Mode: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_up | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_dn | input | 1 | Serial bit entering bit WIDTH-1 on shift down |
| oe_a_n | input | 1 | Active-low bus enable A |
| oe_b_n | input | 1 | Active-low bus enable B |
| bus_in | input | WIDTH | Parallel load data from the shared bus |
| bus_out | output | WIDTH | Register value toward the shared bus |
| bus_drive_en | output | 1 | High when the bus driver should be on |
| ser_out_lo | output | 1 | Bit 0 of the register |
| ser_out_hi | output | 1 | Bit WIDTH-1 of the register |

## Verification
Two functions can fall in the same cycle in this block.

The first pair is reset and an active shift. The bench keeps the select at shift up and lets a chained 16-bit pattern move. Between two clock edges it pulls reset low. It then requires all-zero outputs before the next edge, and again after an edge that still has shift selected.

The second pair is a load capture and the bus driver turning off. In the cycle a load is selected, the bench checks that the drive enable is already low while the enables are low. It then checks that the next edge takes in the externally driven bus value.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHUP = 2'b01,
    MODE_SHDN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output usr_mode_e  mode,
  output logic       drive_en
);
  // Select maps straight onto the mode encoding.
  assign mode = usr_mode_e'(sel);

  // Driver is off when either enable is high or the bus is being read.
  always_comb begin
    drive_en = 1'b1;
    if (oe_a_n || oe_b_n) drive_en = 1'b0;
    if (mode == MODE_LOAD) drive_en = 1'b0;
  end
endmodule

// File: rtl/usr_bit_slice.sv
module usr_bit_slice
  import usr_pkg::*;
(
  input  usr_mode_e mode,
  input  logic      cur_v,
  input  logic      lower_v,
  input  logic      upper_v,
  input  logic      load_v,
  output logic      nxt_v
);
  always_comb begin
    unique case (mode)
      MODE_HOLD: nxt_v = cur_v;
      MODE_SHUP: nxt_v = lower_v;
      MODE_SHDN: nxt_v = upper_v;
      MODE_LOAD: nxt_v = load_v;
      default:   nxt_v = cur_v;
    endcase
  end
endmodule

// File: rtl/usr_core.sv
module usr_core
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  usr_mode_e        mode,
  input  logic             ser_in_up,
  input  logic             ser_in_dn,
  input  logic [WIDTH-1:0] load_d,
  output logic [WIDTH-1:0] q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lower_w, upper_w;
    if (i == 0) begin : g_lo_edge
      assign lower_w = ser_in_up;
    end else begin : g_lo_mid
      assign lower_w = q[i-1];
    end
    if (i == MSB) begin : g_hi_edge
      assign upper_w = ser_in_dn;
    end else begin : g_hi_mid
      assign upper_w = q[i+1];
    end
    usr_bit_slice u_slice (
      .mode    (mode),
      .cur_v   (q[i]),
      .lower_v (lower_w),
      .upper_v (upper_w),
      .load_v  (load_d[i]),
      .nxt_v   (nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOAD) |=> (q == $past(load_d)));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHUP) |=> (q == {$past(q[MSB-1:0]), $past(ser_in_up)}));

  // R3
  shift_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHDN) |=> (q == {$past(ser_in_dn), $past(q[MSB:1])}));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(q));

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (q == '0);
    end
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             ser_in_up,
  input  logic             ser_in_dn,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drive_en,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int MSB = WIDTH - 1;

  usr_mode_e        mode;
  logic [WIDTH-1:0] q;

  usr_ctrl u_ctrl (
    .sel      (sel),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .mode     (mode),
    .drive_en (bus_drive_en)
  );

  usr_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ser_in_up (ser_in_up),
    .ser_in_dn (ser_in_dn),
    .load_d    (bus_in),
    .q         (q)
  );

  assign bus_out    = q;
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[MSB];

  // R7
  load_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !bus_drive_en);

  // R6
  oe_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !bus_drive_en);
endmodule

// File: tb/usr_shift_reg_test.sv
module usr_shift_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic ext_up = 1'b0, ext_dn = 1'b0;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [2*W-1:0] bus_drv = '0;

  logic [W-1:0] lo_out, hi_out;
  logic lo_den, hi_den, lo_s_lo, lo_s_hi, hi_s_lo, hi_s_hi;

  int checks = 0;
  int fails = 0;
  logic [2*W-1:0] model = '0;

  always #10 clk = ~clk;

  // Lower half (bits 7:0) of the chained register
  usr_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .ser_in_up(ext_up), .ser_in_dn(hi_s_lo),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bus_drv[W-1:0]),
    .bus_out(lo_out), .bus_drive_en(lo_den),
    .ser_out_lo(lo_s_lo), .ser_out_hi(lo_s_hi)
  );

  // Upper half (bits 15:8)
  usr_shift_reg #(.WIDTH(W)) uut_hi (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .ser_in_up(lo_s_hi), .ser_in_dn(ext_dn),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bus_drv[2*W-1:W]),
    .bus_out(hi_out), .bus_drive_en(hi_den),
    .ser_out_lo(hi_s_lo), .ser_out_hi(hi_s_hi)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    logic den_exp;
    den_exp = !(oe_a_n || oe_b_n || sel == 2'b11);
    check({req, " R10 bus_out"}, 32'({hi_out, lo_out}), 32'(model));
    check({req, " R9 serial outs"}, 32'({hi_s_hi, hi_s_lo, lo_s_hi, lo_s_lo}),
          32'({model[2*W-1], model[W], model[W-1], model[0]}));
    check({req, " R6 R7 drive_en"}, 32'({hi_den, lo_den}), 32'({den_exp, den_exp}));
  endtask

  // Called at a negedge: drive, clock, update model, compare at next negedge.
  task automatic step(logic [1:0] s, logic up, logic dn, logic [2*W-1:0] b, string req);
    sel = s; ext_up = up; ext_dn = dn; bus_drv = b;
    @(posedge clk);
    case (s)
      2'b01: model = {model[2*W-2:0], up};
      2'b10: model = {dn, model[2*W-1:1]};
      2'b11: model = b;
      default: ;
    endcase
    @(negedge clk);
    check_state(req);
  endtask

  task automatic t_reset_state();
    check_state("R5 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R5 after release");
  endtask

  task automatic t_load();
    sel = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0;
    #1;
    check("R7 load turns bus off", 32'({hi_den, lo_den}), 32'h0);
    step(2'b11, 1'b0, 1'b0, 16'hA5C3, "R1 load");
    step(2'b11, 1'b1, 1'b1, 16'h0F1E, "R1 load again");
  endtask

  task automatic t_hold();
    step(2'b00, 1'b1, 1'b1, 16'hFFFF, "R4 hold with bus noise");
    step(2'b00, 1'b0, 1'b1, 16'h1234, "R4 R10 hold ignores bus");
  endtask

  task automatic t_shift_up();
    for (int k = 0; k < 10; k++)
      step(2'b01, k[0] ^ k[2], 1'b0, 16'hDEAD, "R2 R11 chained shift up");
  endtask

  task automatic t_shift_dn();
    for (int k = 0; k < 10; k++)
      step(2'b10, 1'b0, k[1], 16'hBEEF, "R3 R11 chained shift down");
  endtask

  task automatic t_bus_off();
    oe_a_n = 1'b1; oe_b_n = 1'b0;
    step(2'b01, 1'b1, 1'b0, 16'h0, "R8 shift with oe_a off");
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    step(2'b10, 1'b0, 1'b1, 16'h0, "R8 shift with oe_b off");
    step(2'b11, 1'b0, 1'b0, 16'h3C5A, "R8 load with bus off");
    oe_a_n = 1'b1;
    step(2'b00, 1'b0, 1'b0, 16'h0, "R8 hold with both off");
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    step(2'b00, 1'b0, 1'b0, 16'h0, "R6 both enabled");
  endtask

  task automatic t_reset_mid_shift();
    step(2'b11, 1'b0, 1'b0, 16'h8181, "R1 preload");
    step(2'b01, 1'b1, 1'b0, 16'h0, "R2 shift before reset");
    sel = 2'b01; ext_up = 1'b1;
    #5;
    rst_n = 1'b0;
    model = '0;
    #1;
    check_state("R5 async clear mid shift");
    @(posedge clk);
    @(negedge clk);
    check_state("R5 reset overrides clock and select");
    rst_n = 1'b1;
    step(2'b01, 1'b1, 1'b0, 16'h0, "R2 shift after reset");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_load();
    t_hold();
    t_shift_up();
    t_shift_dn();
    t_bus_off();
    t_reset_mid_shift();
    finish_run();
  end
endmodule